// File: doc/BRIEF.md
# Pipeline RAW Interlock Unit

This unit guards a five-stage in-order pipeline that has no operand bypass and whose register file gives no write-to-read path within one cycle. In every cycle it takes the source register indices of the instruction waiting in decode and compares them with the destinations still in flight in execute, memory and writeback. If any operand would be read before its producer has written it back, the unit raises a stall. The stall stops the program counter and the fetch/decode register from loading, and it sends an empty slot into execute in place of the waiting instruction.

The unit owns the hazard tag of the execute stage: the valid bit, the destination index and the write enable. This register is where the empty slot goes. The memory and writeback tags come in from the surrounding pipeline, which moves them forward every cycle whether or not decode is stalled. The stall is therefore formed without a clock from the current tags. An instruction that depends on the one just ahead of it waits three cycles, and one that sits four slots behind its producer does not wait.

Top module: `raw_interlock`

## Requirements
- R1: `stall` is high when decode is valid, `dec_rs_use` is set, `dec_rs` is nonzero, and `dec_rs` equals the destination of a valid writing instruction held in the execute tag.
- R2: The same match against the memory tag (`mem_dest`, `mem_we`) or the writeback tag (`wb_dest`, `wb_we`) also raises `stall`.
- R3: The second source (`dec_rt`, gated by `dec_rt_use`) is compared against all three stages on its own, with the same rule as the first source.
- R4: Register index 0 never causes a stall, even when its use flag is set and a downstream stage writes index 0.
- R5: No stall occurs when decode is not valid, when the matching source has its use flag clear, or when the matching stage has its write enable clear.
- R6: `pc_load` and `ifid_load` are both low in exactly the cycles in which `stall` is high, and both are high in all other cycles.
- R7: After a clock edge with `stall` high, the execute tag is empty: `ex_valid` = 0 and `ex_we` = 0.
- R8: After a clock edge with `stall` low, the execute tag holds decode's valid bit and destination, and `ex_we` equals `dec_we` when decode is valid and 0 otherwise.
- R9: While reset is held and right after it is released, the execute tag is empty and `stall` is low.
- R10: A reader placed 1, 2, 3 or 4 instruction slots after its producer waits 3, 2, 1 or 0 cycles in decode. It then enters execute with its own destination and write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_valid | input | 1 | Decode holds a real instruction |
| dec_rs | input | IDX_W | First source index in decode |
| dec_rs_use | input | 1 | Decode reads the first source |
| dec_rt | input | IDX_W | Second source index in decode |
| dec_rt_use | input | 1 | Decode reads the second source |
| dec_dest | input | IDX_W | Destination index of the decode instruction |
| dec_we | input | 1 | Decode instruction writes a register |
| mem_dest | input | IDX_W | Destination held in the memory stage |
| mem_we | input | 1 | Memory-stage instruction will write |
| wb_dest | input | IDX_W | Destination held in the writeback stage |
| wb_we | input | 1 | Writeback-stage instruction writes |
| stall | output | 1 | Hold decode; a hazard is open |
| pc_load | output | 1 | Program counter may load |
| ifid_load | output | 1 | Fetch/decode register may load |
| ex_valid | output | 1 | Execute tag holds a real instruction |
| ex_dest | output | IDX_W | Destination in the execute tag |
| ex_we | output | 1 | Execute-stage instruction writes |

## Verification
The properties assume that the memory and writeback tags are a faithful one-cycle and two-cycle delay of the execute tag. Under that assumption a stall always ends once the producer has left writeback. They also assume that the write enable of an empty slot is already low. The stimulus meets both conditions because the bench builds the memory and writeback tags from the unit's own execute tag outputs through two registers, clearing the write enable whenever the tag is not valid. It also holds decode steady for as long as `stall` is high, so no instruction is dropped or repeated.

// File: rtl/raw_ilk_pkg.sv
package raw_ilk_pkg;

  typedef enum logic [1:0] {
    STG_EX  = 2'd0,
    STG_MEM = 2'd1,
    STG_WB  = 2'd2
  } stage_e;

  localparam int STAGE_CNT = 3;
  localparam int SRC_CNT   = 2;

  // One source against one in-flight destination: a hazard only when the
  // source is really read, is not the hardwired zero register, and the
  // stage will write the same index.
  function automatic logic src_conflict(input logic [31:0] src,
                                        input logic        src_used,
                                        input logic [31:0] dst,
                                        input logic        dst_wr);
    return src_used && dst_wr && (src != 32'd0) && (src == dst);
  endfunction

endpackage

// File: rtl/ilk_src_match.sv
module ilk_src_match
  import raw_ilk_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int N_STG = 3
) (
  input  logic [IDX_W-1:0]             src,
  input  logic                         src_used,
  input  logic [N_STG-1:0][IDX_W-1:0]  dst,
  input  logic [N_STG-1:0]             dst_wr,
  output logic [N_STG-1:0]             hit_vec,
  output logic                         hit
);

  for (genvar s = 0; s < N_STG; s++) begin : g_stage
    assign hit_vec[s] = src_conflict(32'(src), src_used, 32'(dst[s]), dst_wr[s]);
  end

  assign hit = |hit_vec;

endmodule

// File: rtl/ilk_ex_slot.sv
module ilk_ex_slot #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insert_bubble,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] in_dest,
  input  logic             in_we,
  output logic             q_valid,
  output logic [IDX_W-1:0] q_dest,
  output logic             q_we
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_dest  <= '0;
      q_we    <= 1'b0;
    end else if (insert_bubble) begin
      q_valid <= 1'b0;
      q_dest  <= '0;
      q_we    <= 1'b0;
    end else begin
      q_valid <= in_valid;
      q_dest  <= in_valid ? in_dest : '0;
      q_we    <= in_valid & in_we;
    end
  end

endmodule

// File: rtl/raw_interlock.sv
module raw_interlock
  import raw_ilk_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic [IDX_W-1:0] dec_rs,
  input  logic             dec_rs_use,
  input  logic [IDX_W-1:0] dec_rt,
  input  logic             dec_rt_use,
  input  logic [IDX_W-1:0] dec_dest,
  input  logic             dec_we,
  input  logic [IDX_W-1:0] mem_dest,
  input  logic             mem_we,
  input  logic [IDX_W-1:0] wb_dest,
  input  logic             wb_we,
  output logic             stall,
  output logic             pc_load,
  output logic             ifid_load,
  output logic             ex_valid,
  output logic [IDX_W-1:0] ex_dest,
  output logic             ex_we
);

  localparam int N_STG = STAGE_CNT;
  localparam int N_SRC = SRC_CNT;

  // In-flight destinations, ordered youngest first.
  logic [N_STG-1:0][IDX_W-1:0] stg_dest;
  logic [N_STG-1:0]            stg_we;

  assign stg_dest[STG_EX]  = ex_dest;
  assign stg_we[STG_EX]    = ex_valid & ex_we;
  assign stg_dest[STG_MEM] = mem_dest;
  assign stg_we[STG_MEM]   = mem_we;
  assign stg_dest[STG_WB]  = wb_dest;
  assign stg_we[STG_WB]    = wb_we;

  logic [N_SRC-1:0][IDX_W-1:0] src_idx;
  logic [N_SRC-1:0]            src_used;
  logic [N_SRC-1:0][N_STG-1:0] src_hit_vec;
  logic [N_SRC-1:0]            src_hit;

  assign src_idx[0]  = dec_rs;
  assign src_used[0] = dec_rs_use;
  assign src_idx[1]  = dec_rt;
  assign src_used[1] = dec_rt_use;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    ilk_src_match #(
      .IDX_W (IDX_W),
      .N_STG (N_STG)
    ) u_match (
      .src      (src_idx[i]),
      .src_used (src_used[i]),
      .dst      (stg_dest),
      .dst_wr   (stg_we),
      .hit_vec  (src_hit_vec[i]),
      .hit      (src_hit[i])
    );
  end

  // Named events for the checker.
  logic rs_hit;
  logic rt_hit;
  assign rs_hit = src_hit[0];
  assign rt_hit = src_hit[1];

  assign stall     = dec_valid & (|src_hit);
  assign pc_load   = ~stall;
  assign ifid_load = ~stall;

  ilk_ex_slot #(
    .IDX_W (IDX_W)
  ) u_ex (
    .clk           (clk),
    .rst_n         (rst_n),
    .insert_bubble (stall),
    .in_valid      (dec_valid),
    .in_dest       (dec_dest),
    .in_we         (dec_we),
    .q_valid       (ex_valid),
    .q_dest        (ex_dest),
    .q_we          (ex_we)
  );

endmodule

// File: rtl/raw_interlock_chk.sv
module raw_interlock_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dec_valid,
  input logic [IDX_W-1:0] dec_rs,
  input logic             dec_rs_use,
  input logic [IDX_W-1:0] dec_rt,
  input logic [IDX_W-1:0] dec_dest,
  input logic             dec_we,
  input logic             stall,
  input logic             pc_load,
  input logic             ifid_load,
  input logic             ex_valid,
  input logic [IDX_W-1:0] ex_dest,
  input logic             ex_we,
  input logic             rt_hit
);

  p_exhit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_rs_use && dec_rs != '0 && ex_valid && ex_we && ex_dest == dec_rs) |-> stall);

  p_rtjoin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && rt_hit) |-> stall);

  p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_rs == '0 && dec_rt == '0) |-> !stall);

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !stall);

  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!pc_load && !ifid_load));

  p_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!ex_valid && !ex_we));

  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && dec_valid) |=> (ex_valid && ex_dest == $past(dec_dest) && ex_we == $past(dec_we)));

endmodule

bind raw_interlock raw_interlock_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dec_valid  (dec_valid),
  .dec_rs     (dec_rs),
  .dec_rs_use (dec_rs_use),
  .dec_rt     (dec_rt),
  .dec_dest   (dec_dest),
  .dec_we     (dec_we),
  .stall      (stall),
  .pc_load    (pc_load),
  .ifid_load  (ifid_load),
  .ex_valid   (ex_valid),
  .ex_dest    (ex_dest),
  .ex_we      (ex_we),
  .rt_hit     (rt_hit)
);

// File: tb/sim_raw_interlock.sv
module sim_raw_interlock;

  localparam int IDX_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             dec_valid = 1'b0;
  logic [IDX_W-1:0] dec_rs = '0;
  logic             dec_rs_use = 1'b0;
  logic [IDX_W-1:0] dec_rt = '0;
  logic             dec_rt_use = 1'b0;
  logic [IDX_W-1:0] dec_dest = '0;
  logic             dec_we = 1'b0;
  logic [IDX_W-1:0] mem_dest;
  logic             mem_we;
  logic [IDX_W-1:0] wb_dest;
  logic             wb_we;
  logic             stall;
  logic             pc_load;
  logic             ifid_load;
  logic             ex_valid;
  logic [IDX_W-1:0] ex_dest;
  logic             ex_we;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  raw_interlock #(.IDX_W(IDX_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .dec_valid(dec_valid), .dec_rs(dec_rs), .dec_rs_use(dec_rs_use),
    .dec_rt(dec_rt), .dec_rt_use(dec_rt_use), .dec_dest(dec_dest), .dec_we(dec_we),
    .mem_dest(mem_dest), .mem_we(mem_we), .wb_dest(wb_dest), .wb_we(wb_we),
    .stall(stall), .pc_load(pc_load), .ifid_load(ifid_load),
    .ex_valid(ex_valid), .ex_dest(ex_dest), .ex_we(ex_we)
  );

  // Downstream stages: they always advance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_dest <= '0; mem_we <= 1'b0; wb_dest <= '0; wb_we <= 1'b0;
    end else begin
      mem_dest <= ex_dest; mem_we <= ex_valid & ex_we;
      wb_dest  <= mem_dest; wb_we <= mem_we;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  typedef struct {
    logic [IDX_W-1:0] dest;
    logic             we;
    int               waits;
    string            req;
  } exp_t;

  exp_t sb[$];

  // Driver: presents one instruction and holds it while stalled.
  task automatic issue(input logic [IDX_W-1:0] rs, input logic rsu,
                       input logic [IDX_W-1:0] rt, input logic rtu,
                       input logic [IDX_W-1:0] dst, input logic we,
                       input int waits, input string req);
    exp_t e;
    bit st;
    @(negedge clk);
    dec_valid = 1'b1; dec_rs = rs; dec_rs_use = rsu; dec_rt = rt; dec_rt_use = rtu;
    dec_dest = dst; dec_we = we;
    e.dest = dst; e.we = we; e.waits = waits; e.req = req;
    sb.push_back(e);
    forever begin
      #5;
      st = stall;
      check(pc_load == !st && ifid_load == !st, "R6 load enables", int'(pc_load), int'(!st));
      @(posedge clk);
      if (!st) break;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    dec_valid = 1'b0; dec_rs_use = 1'b0; dec_rt_use = 1'b0; dec_we = 1'b0;
    dec_rs = 5'd5; dec_rt = 5'd9;
    for (int i = 0; i < n; i++) begin
      #5;
      check(!stall, "R5 invalid decode never stalls", int'(stall), 0);
      @(negedge clk);
    end
  endtask

  // Monitor: pops expected items as instructions reach execute.
  initial begin
    int  wait_cnt = 0;
    bit  prev_stall = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      #6;
      if (rst_n) begin
        if (prev_stall)
          check(!ex_valid && !ex_we, "R7 bubble after stall", int'(ex_valid), 0);
        if (ex_valid) begin
          if (sb.size() == 0) begin
            check(0, "R8 unexpected instruction in execute", 1, 0);
          end else begin
            e = sb.pop_front();
            check(ex_dest == e.dest, {e.req, " R8 dest"}, int'(ex_dest), int'(e.dest));
            check(ex_we == e.we, {e.req, " R8 we"}, int'(ex_we), int'(e.we));
            check(wait_cnt == e.waits, {e.req, " stall cycles"}, wait_cnt, e.waits);
          end
          wait_cnt = 0;
        end
        if (stall) wait_cnt++;
        prev_stall = stall;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    check(!ex_valid && !ex_we, "R9 tag empty in reset", int'(ex_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #6;
    check(!stall && pc_load && ifid_load, "R9 no stall after reset", int'(stall), 0);
    check(!ex_valid, "R9 tag empty after reset", int'(ex_valid), 0);

    // R10 / R1 distance 1 on rs
    issue(5'd0, 0, 5'd0, 0, 5'd5, 1, 0, "R10 producer");
    issue(5'd5, 1, 5'd0, 0, 5'd10, 1, 3, "R10 R1 dist1");
    idle(4);
    // R10 / R2 distance 2
    issue(5'd0, 0, 5'd0, 0, 5'd6, 1, 0, "R10 producer");
    issue(5'd0, 0, 5'd0, 0, 5'd0, 0, 0, "R10 filler");
    issue(5'd6, 1, 5'd0, 0, 5'd11, 1, 2, "R10 R2 dist2");
    idle(4);
    // distance 3
    issue(5'd0, 0, 5'd0, 0, 5'd7, 1, 0, "R10 producer");
    issue(5'd0, 0, 5'd0, 0, 5'd0, 0, 0, "R10 filler");
    issue(5'd0, 0, 5'd0, 0, 5'd0, 0, 0, "R10 filler");
    issue(5'd7, 1, 5'd0, 0, 5'd12, 1, 1, "R10 R2 dist3");
    idle(4);
    // distance 4
    issue(5'd0, 0, 5'd0, 0, 5'd8, 1, 0, "R10 producer");
    issue(5'd0, 0, 5'd0, 0, 5'd0, 0, 0, "R10 filler");
    issue(5'd0, 0, 5'd0, 0, 5'd0, 0, 0, "R10 filler");
    issue(5'd0, 0, 5'd0, 0, 5'd0, 0, 0, "R10 filler");
    issue(5'd8, 1, 5'd0, 0, 5'd13, 1, 0, "R10 dist4");
    idle(4);
    // R3 second source, distance 1
    issue(5'd0, 0, 5'd0, 0, 5'd14, 1, 0, "R3 producer");
    issue(5'd1, 1, 5'd14, 1, 5'd15, 0, 3, "R3 rt dist1");
    idle(4);
    // R4 register zero written and read
    issue(5'd0, 0, 5'd0, 0, 5'd0, 1, 0, "R4 producer of r0");
    issue(5'd0, 1, 5'd0, 1, 5'd16, 1, 0, "R4 r0 read");
    idle(4);
    // R5 use flags clear
    issue(5'd0, 0, 5'd0, 0, 5'd17, 1, 0, "R5 producer");
    issue(5'd17, 0, 5'd17, 0, 5'd18, 1, 0, "R5 use clear");
    idle(4);
    // R5 producer does not write
    issue(5'd0, 0, 5'd0, 0, 5'd19, 0, 0, "R5 non-writer");
    issue(5'd19, 1, 5'd19, 1, 5'd20, 1, 0, "R5 we clear");
    idle(4);
    // R2 R3 two producers, reader waits on the younger
    issue(5'd0, 0, 5'd0, 0, 5'd21, 1, 0, "R2 older producer");
    issue(5'd0, 0, 5'd0, 0, 5'd22, 1, 0, "R2 younger producer");
    issue(5'd21, 1, 5'd22, 1, 5'd23, 1, 3, "R2 R3 two sources");
    // R8 back-to-back independent instructions
    issue(5'd2, 1, 5'd3, 1, 5'd24, 1, 0, "R8 independent");
    issue(5'd4, 1, 5'd25, 1, 5'd26, 0, 0, "R8 independent");
    idle(6);
    check(sb.size() == 0, "R8 all instructions reached execute", sb.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule